// File: doc/BRIEF.md
# Address-Register Effective Address Unit

This unit produces the memory operand address for a simple 32-bit big-endian processor. It holds the bank of address registers. Each cycle it takes one operand description: an addressing-mode code, an address-register index, an operand size and a displacement. It returns the effective address at once. For the auto-adjusting modes it also produces the adjusted register value, and that value is written back into the bank on the next clock edge.

The unit also merges a result into a data register according to operand size. A byte or word result replaces only the low bits of the old data-register value, and the upper bits are kept. The caller loads address registers through a dedicated load port, which plays the role of an address-register move. Memory is big-endian, so the byte at the effective address is the most significant byte of a multi-byte operand. Decoding instructions, driving the memory and producing flags are left to surrounding logic.

Top module: `ea_unit`

## Requirements
- R1: After reset every address register reads as zero.
- R2: When `ld_en` is high, register `ld_idx` takes `ld_data` at the next clock edge. This load has priority over an auto-adjust writeback to the same register in the same cycle.
- R3: Mode code 2 (register indirect) gives `ea` = An with `ea_valid` high and leaves An unchanged.
- R4: Mode code 3 (displacement) gives `ea` = An plus the sign-extended 16-bit `op_disp` and leaves An unchanged.
- R5: Mode code 4 (pre-decrement) gives `ea` = An minus the step, asserts `an_we` with `an_wdata` = `ea`, and An holds that value after the clock edge.
- R6: Mode code 5 (post-increment) gives `ea` = the current An, asserts `an_we` with `an_wdata` = An plus the step, and An holds that value after the clock edge.
- R7: The step follows `op_size`: code 0 (byte) is 1, code 1 (word) is 2, code 2 (long) is 4, and code 3 is treated as long.
- R8: Mode codes 0 (immediate), 1 (data register direct), 6 and 7 keep `ea_valid` and `an_we` low and change no address register.
- R9: With word size, `dreg_merged` holds `alu_result[15:0]` in bits 15:0 and `dreg_old[31:16]` above them. For example, old 0xFFFFFFFF with result 0x00000002 gives 0xFFFF0002.
- R10: With byte size, `dreg_merged` holds `alu_result[7:0]` in bits 7:0 and `dreg_old` above them.
- R11: With long size (code 2 or 3), `dreg_merged` equals `alu_result`.
- R12: While `op_valid` is low, `ea_valid` and `an_we` stay low and no register changes except through the load port.
- R13: All address arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operand is presented this cycle |
| op_mode | input | 3 | Addressing-mode code |
| op_areg | input | 3 | Address-register index |
| op_size | input | 2 | Operand size code |
| op_disp | input | 16 | Displacement |
| ld_en | input | 1 | Load an address register |
| ld_idx | input | 3 | Index of the register to load |
| ld_data | input | 32 | Value to load |
| dreg_old | input | 32 | Current data-register value |
| alu_result | input | 32 | New value to merge into it |
| ea | output | 32 | Effective address |
| ea_valid | output | 1 | `ea` refers to memory |
| an_wdata | output | 32 | Adjusted address-register value |
| an_we | output | 1 | Adjusted value is written back this cycle |
| dreg_merged | output | 32 | Data-register value after the size-aware merge |

## Verification
The bench builds the unit with its default parameters: 32-bit addresses and data, a 16-bit sign-extended displacement and eight address registers. With these values the wrap of the address arithmetic at the 32-bit boundary can be reached from register values near 0xFFFFFFFF. Negative displacements and all four size codes also come within reach in both auto-adjust modes. Back-to-back adjustments of one register and a load that collides with a writeback are exercised as well.

// File: rtl/ea_pkg.sv
package ea_pkg;

   typedef enum logic [2:0] {
      AM_IMM     = 3'd0,
      AM_DREG    = 3'd1,
      AM_IND     = 3'd2,
      AM_DISP    = 3'd3,
      AM_PREDEC  = 3'd4,
      AM_POSTINC = 3'd5
   } amode_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2,
      SZ_RSVD = 2'd3
   } osize_e;

   function automatic logic [2:0] size_step(input logic [1:0] sz);
      case (sz)
         SZ_BYTE: size_step = 3'd1;
         SZ_WORD: size_step = 3'd2;
         default: size_step = 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/ea_areg_bank.sv
module ea_areg_bank #(
   parameter int NREG  = 8,
   parameter int WIDTH = 32,
   localparam int IW   = $clog2(NREG)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ld_en,
   input  logic [IW-1:0]              ld_idx,
   input  logic [WIDTH-1:0]           ld_data,
   input  logic                       wb_en,
   input  logic [IW-1:0]              wb_idx,
   input  logic [WIDTH-1:0]           wb_data,
   input  logic [IW-1:0]              rd_idx,
   output logic [WIDTH-1:0]           rd_data,
   output logic [NREG-1:0][WIDTH-1:0] regs_q
);

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs_q[g] <= '0;
         else if (ld_en && ld_idx == IW'(g))
            regs_q[g] <= ld_data;
         else if (wb_en && wb_idx == IW'(g))
            regs_q[g] <= wb_data;
      end
   end

   assign rd_data = regs_q[rd_idx];

endmodule

// File: rtl/ea_calc.sv
module ea_calc
   import ea_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int DISP_W   = 16,
   parameter bit SIGN_EXT = 1'b1
) (
   input  logic              valid,
   input  logic [2:0]        mode,
   input  logic [1:0]        size,
   input  logic [DISP_W-1:0] disp,
   input  logic [ADDR_W-1:0] base,
   output logic [ADDR_W-1:0] ea,
   output logic              ea_valid,
   output logic              wb_req,
   output logic [ADDR_W-1:0] wb_data
);

   logic [ADDR_W-1:0] disp_ext;
   logic [ADDR_W-1:0] step;
   logic [ADDR_W-1:0] dec_val;
   logic [ADDR_W-1:0] inc_val;

   if (SIGN_EXT) begin : g_sext
      assign disp_ext = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
   end else begin : g_zext
      assign disp_ext = {{(ADDR_W-DISP_W){1'b0}}, disp};
   end

   assign step    = ADDR_W'(size_step(size));
   assign dec_val = base - step;
   assign inc_val = base + step;

   always_comb begin
      ea       = '0;
      ea_valid = 1'b0;
      wb_req   = 1'b0;
      wb_data  = base;
      if (valid) begin
         case (mode)
            AM_IND: begin
               ea       = base;
               ea_valid = 1'b1;
            end
            AM_DISP: begin
               ea       = base + disp_ext;
               ea_valid = 1'b1;
            end
            AM_PREDEC: begin
               ea       = dec_val;
               ea_valid = 1'b1;
               wb_req   = 1'b1;
               wb_data  = dec_val;
            end
            AM_POSTINC: begin
               ea       = base;
               ea_valid = 1'b1;
               wb_req   = 1'b1;
               wb_data  = inc_val;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/ea_dmerge.sv
module ea_dmerge
   import ea_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [1:0]        size,
   input  logic [DATA_W-1:0] old_val,
   input  logic [DATA_W-1:0] res_val,
   output logic [DATA_W-1:0] merged
);

   always_comb begin
      case (size)
         SZ_BYTE: merged = {old_val[DATA_W-1:8],  res_val[7:0]};
         SZ_WORD: merged = {old_val[DATA_W-1:16], res_val[15:0]};
         default: merged = res_val;
      endcase
   end

endmodule

// File: rtl/ea_unit.sv
module ea_unit
   import ea_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int DISP_W   = 16,
   parameter int NUM_AREG = 8,
   parameter bit SIGN_EXT = 1'b1,
   localparam int IDX_W   = $clog2(NUM_AREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [2:0]        op_mode,
   input  logic [IDX_W-1:0]  op_areg,
   input  logic [1:0]        op_size,
   input  logic [DISP_W-1:0] op_disp,
   input  logic              ld_en,
   input  logic [IDX_W-1:0]  ld_idx,
   input  logic [ADDR_W-1:0] ld_data,
   input  logic [DATA_W-1:0] dreg_old,
   input  logic [DATA_W-1:0] alu_result,
   output logic [ADDR_W-1:0] ea,
   output logic              ea_valid,
   output logic [ADDR_W-1:0] an_wdata,
   output logic              an_we,
   output logic [DATA_W-1:0] dreg_merged
);

   if (DISP_W > ADDR_W) begin : g_bad_disp
      $error("ea_unit: DISP_W must not exceed ADDR_W");
   end
   if (DATA_W < 32) begin : g_bad_data
      $error("ea_unit: DATA_W must be at least 32");
   end
   if (NUM_AREG < 2 || (1 << IDX_W) != NUM_AREG) begin : g_bad_nreg
      $error("ea_unit: NUM_AREG must be a power of two of at least 2");
   end

   logic [ADDR_W-1:0]                base_q;
   logic [NUM_AREG-1:0][ADDR_W-1:0]  bank_q;

   ea_areg_bank #(.NREG(NUM_AREG), .WIDTH(ADDR_W)) bank_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_en   (ld_en),
      .ld_idx  (ld_idx),
      .ld_data (ld_data),
      .wb_en   (an_we),
      .wb_idx  (op_areg),
      .wb_data (an_wdata),
      .rd_idx  (op_areg),
      .rd_data (base_q),
      .regs_q  (bank_q)
   );

   ea_calc #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .SIGN_EXT(SIGN_EXT)) calc_i (
      .valid    (op_valid),
      .mode     (op_mode),
      .size     (op_size),
      .disp     (op_disp),
      .base     (base_q),
      .ea       (ea),
      .ea_valid (ea_valid),
      .wb_req   (an_we),
      .wb_data  (an_wdata)
   );

   ea_dmerge #(.DATA_W(DATA_W)) merge_i (
      .size    (op_size),
      .old_val (dreg_old),
      .res_val (alu_result),
      .merged  (dreg_merged)
   );

endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk
   import ea_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int DISP_W   = 16,
   parameter int NUM_AREG = 8,
   parameter bit SIGN_EXT = 1'b1,
   localparam int IDX_W   = $clog2(NUM_AREG)
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic                             op_valid,
   input logic [2:0]                       op_mode,
   input logic [IDX_W-1:0]                 op_areg,
   input logic [1:0]                       op_size,
   input logic [DISP_W-1:0]                op_disp,
   input logic                             ld_en,
   input logic [IDX_W-1:0]                 ld_idx,
   input logic [ADDR_W-1:0]                ld_data,
   input logic [DATA_W-1:0]                dreg_old,
   input logic [DATA_W-1:0]                alu_result,
   input logic [ADDR_W-1:0]                ea,
   input logic                             ea_valid,
   input logic [ADDR_W-1:0]                an_wdata,
   input logic                             an_we,
   input logic [DATA_W-1:0]                dreg_merged,
   input logic [ADDR_W-1:0]                base_q,
   input logic [NUM_AREG-1:0][ADDR_W-1:0]  bank_q
);

   logic [ADDR_W-1:0] chk_step;
   logic [ADDR_W-1:0] chk_disp;
   assign chk_step = ADDR_W'(size_step(op_size));
   assign chk_disp = SIGN_EXT ? ADDR_W'($signed(op_disp)) : ADDR_W'(op_disp);

   assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |=> bank_q[$past(ld_idx)] == $past(ld_data));

   assert_indirect_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_mode == 3'd2) |-> (ea == base_q && ea_valid && !an_we));

   assert_disp_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_mode == 3'd3) |-> (ea == base_q + chk_disp && !an_we));

   assert_predec_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_mode == 3'd4) |-> (base_q - ea == chk_step && an_we && an_wdata == ea));

   assert_postinc_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_mode == 3'd5) |-> (ea == base_q && an_we && an_wdata - base_q == chk_step));

   assert_writeback_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (an_we && !(ld_en && ld_idx == op_areg)) |=> bank_q[$past(op_areg)] == $past(an_wdata));

   assert_we_modes_R8: assert property (@(posedge clk) disable iff (!rst_n)
      an_we |-> (op_valid && (op_mode == 3'd4 || op_mode == 3'd5)));

   assert_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |-> (!ea_valid && !an_we));

   assert_word_merge_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_size == 2'd1) |-> (dreg_merged[DATA_W-1:16] == dreg_old[DATA_W-1:16]
                             && dreg_merged[15:0] == alu_result[15:0]));

   assert_byte_merge_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (op_size == 2'd0) |-> (dreg_merged[DATA_W-1:8] == dreg_old[DATA_W-1:8]
                             && dreg_merged[7:0] == alu_result[7:0]));

   assert_long_merge_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (op_size[1]) |-> dreg_merged == alu_result);

endmodule

bind ea_unit ea_unit_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DISP_W(DISP_W),
   .NUM_AREG(NUM_AREG), .SIGN_EXT(SIGN_EXT)
) chk_i (
   .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_mode(op_mode),
   .op_areg(op_areg), .op_size(op_size), .op_disp(op_disp),
   .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
   .dreg_old(dreg_old), .alu_result(alu_result), .ea(ea),
   .ea_valid(ea_valid), .an_wdata(an_wdata), .an_we(an_we),
   .dreg_merged(dreg_merged), .base_q(base_q), .bank_q(bank_q)
);

// File: tb/ea_unit_tb.sv
module ea_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [2:0]  op_mode = '0;
   logic [2:0]  op_areg = '0;
   logic [1:0]  op_size = '0;
   logic [15:0] op_disp = '0;
   logic        ld_en = 1'b0;
   logic [2:0]  ld_idx = '0;
   logic [31:0] ld_data = '0;
   logic [31:0] dreg_old = '0;
   logic [31:0] alu_result = '0;
   logic [31:0] ea;
   logic        ea_valid;
   logic [31:0] an_wdata;
   logic        an_we;
   logic [31:0] dreg_merged;

   int checks = 0;
   int errors = 0;
   logic [31:0] s_ea;
   logic        s_ev;
   logic        s_we;

   always #10 clk = ~clk;

   ea_unit dut_i (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_mode(op_mode),
      .op_areg(op_areg), .op_size(op_size), .op_disp(op_disp),
      .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
      .dreg_old(dreg_old), .alu_result(alu_result), .ea(ea),
      .ea_valid(ea_valid), .an_wdata(an_wdata), .an_we(an_we),
      .dreg_merged(dreg_merged)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic load_reg(input logic [2:0] idx, input logic [31:0] val);
      @(negedge clk);
      ld_en = 1'b1; ld_idx = idx; ld_data = val;
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   // present one operand, sample before the edge, let the edge write back
   task automatic apply(input logic v, input logic [2:0] m, input logic [2:0] r,
                        input logic [1:0] s, input logic [15:0] d);
      @(negedge clk);
      op_valid = v; op_mode = m; op_areg = r; op_size = s; op_disp = d;
      #5;
      s_ea = ea; s_ev = ea_valid; s_we = an_we;
      @(negedge clk);
      op_valid = 1'b0;
   endtask

   task automatic read_reg(input logic [2:0] r, output logic [31:0] val);
      apply(1'b1, 3'd2, r, 2'd2, 16'h0);
      val = s_ea;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      for (int i = 0; i < 8; i++) begin
         read_reg(3'(i), v);
         check("R1 reset value", v, 32'h0);
      end
   endtask

   task automatic t_load_indirect;
      load_reg(3'd2, 32'h0000_1000);
      apply(1'b1, 3'd2, 3'd2, 2'd1, 16'h0);
      check("R2/R3 indirect ea", s_ea, 32'h0000_1000);
      check("R3 ea_valid", {31'b0, s_ev}, 32'h1);
      check("R3 no writeback", {31'b0, s_we}, 32'h0);
   endtask

   task automatic t_disp;
      logic [31:0] v;
      apply(1'b1, 3'd3, 3'd2, 2'd2, 16'h0006);
      check("R4 positive disp", s_ea, 32'h0000_1006);
      apply(1'b1, 3'd3, 3'd2, 2'd2, 16'hFFFE);
      check("R4 negative disp", s_ea, 32'h0000_0FFE);
      check("R4 no writeback", {31'b0, s_we}, 32'h0);
      read_reg(3'd2, v);
      check("R4 An unchanged", v, 32'h0000_1000);
   endtask

   task automatic t_predec;
      logic [31:0] v;
      load_reg(3'd1, 32'h0000_0100);
      apply(1'b1, 3'd4, 3'd1, 2'd0, 16'h0);
      check("R5/R7 predec byte", s_ea, 32'h0000_00FF);
      apply(1'b1, 3'd4, 3'd1, 2'd1, 16'h0);
      check("R5/R7 predec word", s_ea, 32'h0000_00FD);
      apply(1'b1, 3'd4, 3'd1, 2'd2, 16'h0);
      check("R5/R7 predec long", s_ea, 32'h0000_00F9);
      apply(1'b1, 3'd4, 3'd1, 2'd3, 16'h0);
      check("R5/R7 predec size code 3", s_ea, 32'h0000_00F5);
      read_reg(3'd1, v);
      check("R5 final An", v, 32'h0000_00F5);
   endtask

   task automatic t_postinc;
      logic [31:0] v;
      load_reg(3'd0, 32'h0000_0200);
      apply(1'b1, 3'd5, 3'd0, 2'd0, 16'h0);
      check("R6 postinc byte ea", s_ea, 32'h0000_0200);
      apply(1'b1, 3'd5, 3'd0, 2'd1, 16'h0);
      check("R6/R7 postinc word ea", s_ea, 32'h0000_0201);
      apply(1'b1, 3'd5, 3'd0, 2'd2, 16'h0);
      check("R6/R7 postinc long ea", s_ea, 32'h0000_0203);
      read_reg(3'd0, v);
      check("R6/R7 final An", v, 32'h0000_0207);
   endtask

   task automatic t_wrap;
      logic [31:0] v;
      load_reg(3'd5, 32'hFFFF_FFFE);
      apply(1'b1, 3'd3, 3'd5, 2'd2, 16'h0004);
      check("R13 disp wrap", s_ea, 32'h0000_0002);
      apply(1'b1, 3'd5, 3'd5, 2'd2, 16'h0);
      check("R13 postinc ea", s_ea, 32'hFFFF_FFFE);
      read_reg(3'd5, v);
      check("R13 postinc wrap", v, 32'h0000_0002);
      apply(1'b1, 3'd4, 3'd5, 2'd2, 16'h0);
      check("R13 predec wrap", s_ea, 32'hFFFF_FFFE);
   endtask

   task automatic t_nonmem;
      logic [31:0] v;
      load_reg(3'd3, 32'h0000_3000);
      for (int m = 0; m < 8; m++) begin
         if (m >= 2 && m <= 5) continue;
         apply(1'b1, 3'(m), 3'd3, 2'd2, 16'h0010);
         check("R8 ea_valid low", {31'b0, s_ev}, 32'h0);
         check("R8 an_we low", {31'b0, s_we}, 32'h0);
      end
      read_reg(3'd3, v);
      check("R8 An unchanged", v, 32'h0000_3000);
   endtask

   task automatic t_idle;
      logic [31:0] v;
      apply(1'b0, 3'd5, 3'd3, 2'd2, 16'h0);
      check("R12 ea_valid idle", {31'b0, s_ev}, 32'h0);
      check("R12 an_we idle", {31'b0, s_we}, 32'h0);
      apply(1'b0, 3'd4, 3'd3, 2'd2, 16'h0);
      read_reg(3'd3, v);
      check("R12 An unchanged", v, 32'h0000_3000);
   endtask

   task automatic t_collide;
      logic [31:0] v;
      load_reg(3'd4, 32'h0000_4000);
      @(negedge clk);
      op_valid = 1'b1; op_mode = 3'd5; op_areg = 3'd4; op_size = 2'd2;
      ld_en = 1'b1; ld_idx = 3'd4; ld_data = 32'h0000_ABCD;
      @(negedge clk);
      op_valid = 1'b0; ld_en = 1'b0;
      read_reg(3'd4, v);
      check("R2 load beats writeback", v, 32'h0000_ABCD);
   endtask

   task automatic t_merge;
      dreg_old = 32'hFFFF_FFFF; alu_result = 32'h0000_0002; op_size = 2'd1;
      #1 check("R9 word merge", dreg_merged, 32'hFFFF_0002);
      dreg_old = 32'h1234_5678; alu_result = 32'hAABB_CCDD; op_size = 2'd0;
      #1 check("R10 byte merge", dreg_merged, 32'h1234_56DD);
      op_size = 2'd2;
      #1 check("R11 long merge", dreg_merged, 32'hAABB_CCDD);
      op_size = 2'd3;
      #1 check("R11 size code 3 merge", dreg_merged, 32'hAABB_CCDD);
   endtask

   initial begin
      #(20 * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_load_indirect();
      t_disp();
      t_predec();
      t_postinc();
      t_wrap();
      t_nonmem();
      t_idle();
      t_collide();
      @(negedge clk);
      t_merge();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule